// File: doc/BRIEF.md
# Dual-Mode Pulse Accumulator

This block is a 16-bit counter driven by one external pin, the pin that the last timer channel also uses. It has two modes. In event mode it adds one for every pin edge of a chosen polarity. In gated mode it adds one for every divide-by-64 tick that arrives while the pin holds a chosen level, and it marks the end of each such level window with a flag. The divide-by-64 tick comes from outside the block. When the main timer is stopped, that tick is absent, so gated mode does not advance while event mode keeps counting.

The pin passes through a synchronizer before anything else looks at it. Two sticky flags record a count rollover and a counted or trailing pin edge. Each flag drives an interrupt request through its own enable. A small register bus gives software three things: it can load and read the count, read the flags, and clear the flags by writing ones. When the fast-clear control is on, any read or write of the count clears both flags.

Top module: `pacc_top`

## Requirements
- R1: After reset the count is 0, both flags are 0 and both interrupt requests are low.
- R2: In event mode (`gateMode`=0) with `accEn`=1, `edgeSel`=1 makes each rising pin edge add one to the count and `edgeSel`=0 makes each falling edge add one. Edges of the other polarity leave the count unchanged.
- R3: In event mode, each counted edge sets the input flag.
- R4: In gated mode (`gateMode`=1) with `accEn`=1, each cycle with `tickDiv64`=1 adds one to the count while the synchronized pin is low (`edgeSel`=1) or high (`edgeSel`=0). With the pin at the other level, or with no tick, the count holds. Pin edges alone never count in this mode.
- R5: In gated mode, the trailing edge of the active window sets the input flag. This is the rising edge when `edgeSel`=1 and the falling edge when `edgeSel`=0. The leading edge does not set it.
- R6: An increment from FFFF wraps the count to 0000 and sets the overflow flag.
- R7: The flag register sits at bus address 1. Bit 1 is the overflow flag and bit 0 is the input flag, and the other bits read 0. Writing 1 to a bit clears that flag and writing 0 leaves it alone. If a flag is set and cleared in the same cycle, it ends up set.
- R8: With `fastClr`=1, any read or write at bus address 0 (the count) clears both flags. With `fastClr`=0, reading the count leaves the flags unchanged.
- R9: A write at bus address 0 loads the written value into the count at any time, and this load takes priority over an increment in the same cycle. A read at address 0 returns the count.
- R10: `ovfIrq` equals the overflow flag ANDed with `ovfIrqEn`, and `inIrq` equals the input flag ANDed with `inIrqEn`.
- R11: With `accEn`=0, neither pin edges nor ticks change the count or set either flag.
- R12: Suppose the pin is first sampled at its new level on clock edge n. The count does not reflect that edge after clock edge n+1, and it does reflect it after clock edge n+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pinRaw | input | 1 | Unsynchronized accumulator pin |
| tickDiv64 | input | 1 | One-cycle divide-by-64 tick (absent while the timer is stopped) |
| accEn | input | 1 | Accumulator enable |
| gateMode | input | 1 | 0 selects event mode, 1 selects gated mode |
| edgeSel | input | 1 | Polarity / level select |
| ovfIrqEn | input | 1 | Overflow interrupt enable |
| inIrqEn | input | 1 | Input-edge interrupt enable |
| fastClr | input | 1 | Count accesses clear both flags |
| busAddr | input | 2 | Register address: 0 selects the count, 1 selects the flags |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data for the addressed register |
| count | output | 16 | Current count |
| ovfFlag | output | 1 | Overflow flag |
| inFlag | output | 1 | Input-edge flag |
| ovfIrq | output | 1 | Overflow interrupt request |
| inIrq | output | 1 | Input-edge interrupt request |

## Verification
Two functions can fall in the same cycle. A flag can be set by a counted edge while software clears it, and the count can be incremented by a counted edge while software loads it. To provoke each case, the bench counts clock edges from the pin change and places the bus write in exactly the cycle the synchronized edge takes effect. It then expects the input flag to stay set and the count to hold the loaded value with no extra increment. A long random mix of edges, ticks, loads, flag writes and count reads in both modes and both polarities is compared against a bench model after every operation.

// File: rtl/pacc_pkg.sv
package pacc_pkg;

  // Register addresses on the accumulator bus
  localparam int CNT_ADDR = 0;
  localparam int FLG_ADDR = 1;

  // Flag positions inside the flag register
  localparam int OVF_BIT = 1;
  localparam int IN_BIT  = 0;

  // Strobes from the control to the datapath, valid for one cycle
  typedef struct packed {
    logic incr;    // add one to the count
    logic load;    // load bus write data into the count
    logic setIn;   // set the input flag
    logic clrOvf;  // clear the overflow flag
    logic clrIn;   // clear the input flag
  } accStrobe_t;

endpackage

// File: rtl/pacc_sync.sv
module pacc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinRaw,
  output logic pinLvl,
  output logic pinRise,
  output logic pinFall
);

  logic [STAGES-1:0] chain;
  logic prevLvl;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= pinRaw;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], pinRaw};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLvl <= 1'b0;
    else       prevLvl <= pinLvl;
  end

  assign pinLvl  = chain[STAGES-1];
  assign pinRise = pinLvl & ~prevLvl;
  assign pinFall = ~pinLvl & prevLvl;

  // R12
  edge_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pinRise || pinFall) |=> !(pinRise || pinFall));

endmodule

// File: rtl/pacc_ctrl.sv
module pacc_ctrl
  import pacc_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pinLvl,
  input  logic              pinRise,
  input  logic              pinFall,
  input  logic              tickDiv64,
  input  logic              accEn,
  input  logic              gateMode,
  input  logic              edgeSel,
  input  logic              fastClr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CNT_W-1:0]  busWdata,
  output accStrobe_t        stb
);

  logic selEdge;
  logic activeLvl;
  logic hitCnt;
  logic hitFlg;
  logic cntAccess;
  logic countEvt;

  always_comb begin
    // the same polarity marks a counted edge (event) and a trailing edge (gated)
    selEdge   = edgeSel ? pinRise : pinFall;
    activeLvl = edgeSel ? ~pinLvl : pinLvl;
    hitCnt    = (busAddr == ADDR_W'(CNT_ADDR));
    hitFlg    = (busAddr == ADDR_W'(FLG_ADDR));
    cntAccess = fastClr && hitCnt && (busWr || busRd);
    countEvt  = gateMode ? (tickDiv64 && activeLvl) : selEdge;

    stb        = '0;
    stb.load   = busWr && hitCnt;
    stb.incr   = accEn && countEvt && !stb.load;
    stb.setIn  = accEn && selEdge;
    stb.clrOvf = cntAccess || (busWr && hitFlg && busWdata[OVF_BIT]);
    stb.clrIn  = cntAccess || (busWr && hitFlg && busWdata[IN_BIT]);
  end

  // R4
  gated_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.incr && gateMode) |-> tickDiv64);

  // R2
  event_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.incr && !gateMode) |-> (pinRise || pinFall));

endmodule

// File: rtl/pacc_dp.sv
module pacc_dp
  import pacc_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  accStrobe_t        stb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CNT_W-1:0]  busWdata,
  output logic [CNT_W-1:0]  count,
  output logic              ovfFlag,
  output logic              inFlag,
  output logic [CNT_W-1:0]  busRdata
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic wrap;

  assign wrap = stb.incr && (count == CNT_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (stb.load) begin
      count <= busWdata;
    end else if (stb.incr) begin
      count <= count + 1'b1;
    end
  end

  // a set in the same cycle as a clear wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfFlag <= 1'b0;
      inFlag  <= 1'b0;
    end else begin
      if (wrap)            ovfFlag <= 1'b1;
      else if (stb.clrOvf) ovfFlag <= 1'b0;
      if (stb.setIn)       inFlag  <= 1'b1;
      else if (stb.clrIn)  inFlag  <= 1'b0;
    end
  end

  always_comb begin
    busRdata = '0;
    if (busAddr == ADDR_W'(CNT_ADDR)) begin
      busRdata = count;
    end else if (busAddr == ADDR_W'(FLG_ADDR)) begin
      busRdata[OVF_BIT] = ovfFlag;
      busRdata[IN_BIT]  = inFlag;
    end
  end

  // R6
  wrap_ovf_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.incr && !stb.load && count == CNT_MAX) |=> (ovfFlag && count == '0));

  // R2
  incr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.incr && !stb.load && count != CNT_MAX) |=> (count == $past(count) + 1'b1));

  // R9
  load_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> (count == $past(busWdata)));

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.setIn |=> inFlag);

  // R7
  in_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clrIn && !stb.setIn) |=> !inFlag);

endmodule

// File: rtl/pacc_top.sv
module pacc_top
  import pacc_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pinRaw,
  input  logic              tickDiv64,
  input  logic              accEn,
  input  logic              gateMode,
  input  logic              edgeSel,
  input  logic              ovfIrqEn,
  input  logic              inIrqEn,
  input  logic              fastClr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [CNT_W-1:0]  busWdata,
  output logic [CNT_W-1:0]  busRdata,
  output logic [CNT_W-1:0]  count,
  output logic              ovfFlag,
  output logic              inFlag,
  output logic              ovfIrq,
  output logic              inIrq
);

  logic pinLvl;
  logic pinRise;
  logic pinFall;
  accStrobe_t stb;

  pacc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .pinRaw(pinRaw),
    .pinLvl(pinLvl), .pinRise(pinRise), .pinFall(pinFall)
  );

  pacc_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .pinLvl(pinLvl), .pinRise(pinRise), .pinFall(pinFall),
    .tickDiv64(tickDiv64), .accEn(accEn), .gateMode(gateMode),
    .edgeSel(edgeSel), .fastClr(fastClr),
    .busWr(busWr), .busRd(busRd), .busAddr(busAddr), .busWdata(busWdata),
    .stb(stb)
  );

  pacc_dp #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .busAddr(busAddr), .busWdata(busWdata),
    .count(count), .ovfFlag(ovfFlag), .inFlag(inFlag), .busRdata(busRdata)
  );

  assign ovfIrq = ovfFlag & ovfIrqEn;
  assign inIrq  = inFlag & inIrqEn;

  // R11
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!accEn && !(busWr && busAddr == ADDR_W'(CNT_ADDR))) |=> $stable(count));

  // R11
  disabled_noflag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!accEn && !inFlag) |=> !inFlag);

endmodule

// File: tb/tb_pacc_top.sv
module tb_pacc_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pinRaw = 1'b0;
  logic        tickDiv64 = 1'b0;
  logic        accEn = 1'b0;
  logic        gateMode = 1'b0;
  logic        edgeSel = 1'b1;
  logic        ovfIrqEn = 1'b0;
  logic        inIrqEn = 1'b0;
  logic        fastClr = 1'b0;
  logic [1:0]  busAddr = 2'd0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [15:0] busWdata = 16'h0;
  logic [15:0] busRdata;
  logic [15:0] count;
  logic        ovfFlag, inFlag, ovfIrq, inIrq;

  always #2 clk = ~clk;

  pacc_top dut (
    .clk(clk), .rstN(rstN), .pinRaw(pinRaw), .tickDiv64(tickDiv64),
    .accEn(accEn), .gateMode(gateMode), .edgeSel(edgeSel),
    .ovfIrqEn(ovfIrqEn), .inIrqEn(inIrqEn), .fastClr(fastClr),
    .busAddr(busAddr), .busWr(busWr), .busRd(busRd), .busWdata(busWdata),
    .busRdata(busRdata), .count(count), .ovfFlag(ovfFlag), .inFlag(inFlag),
    .ovfIrq(ovfIrq), .inIrq(inIrq)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model
  logic [15:0] mCnt = 16'h0;
  logic        mOvf = 1'b0;
  logic        mIn  = 1'b0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chkState(string req);
    chk(req, "count", 32'(count), 32'(mCnt));
    chk(req, "ovfFlag", 32'(ovfFlag), 32'(mOvf));
    chk(req, "inFlag", 32'(inFlag), 32'(mIn));
    chk("R10", "ovfIrq", 32'(ovfIrq), 32'(mOvf & ovfIrqEn));
    chk("R10", "inIrq", 32'(inIrq), 32'(mIn & inIrqEn));
  endtask

  function automatic bit edgeHits(bit rising);
    return accEn && (rising == edgeSel);
  endfunction

  function automatic bit tickHits(bit lvl);
    return accEn && gateMode && (lvl == !edgeSel);
  endfunction

  task automatic modelIncr();
    if (mCnt == 16'hFFFF) mOvf = 1'b1;
    mCnt = mCnt + 16'h1;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic togglePin();
    bit rising;
    @(negedge clk);
    pinRaw = ~pinRaw;
    rising = pinRaw;
    idle(4);
    if (edgeHits(rising)) begin
      mIn = 1'b1;
      if (!gateMode) modelIncr();
    end
  endtask

  task automatic tickPulse();
    @(negedge clk);
    tickDiv64 = 1'b1;
    @(negedge clk);
    tickDiv64 = 1'b0;
    idle(1);
    if (tickHits(pinRaw)) modelIncr();
  endtask

  task automatic busWrite(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
    if (a == 2'd0) begin
      mCnt = d;
      if (fastClr) begin mOvf = 1'b0; mIn = 1'b0; end
    end else if (a == 2'd1) begin
      if (d[1]) mOvf = 1'b0;
      if (d[0]) mIn = 1'b0;
    end
  endtask

  task automatic busRead(logic [1:0] a, string req);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    #1;
    if (a == 2'd0) chk(req, "read count", 32'(busRdata), 32'(mCnt));
    else if (a == 2'd1) chk(req, "read flags", 32'(busRdata), {30'b0, mOvf, mIn});
    else chk(req, "read unmapped", 32'(busRdata), 32'h0);
    @(negedge clk);
    busRd = 1'b0;
    if (a == 2'd0 && fastClr) begin mOvf = 1'b0; mIn = 1'b0; end
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      finishRun();
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    idle(3);
    rstN = 1'b1;
    idle(1);
    chkState("R1");

    // R12 latency and R2 rising edge in event mode
    accEn = 1'b1; gateMode = 1'b0; edgeSel = 1'b1;
    @(negedge clk);
    pinRaw = 1'b1;           // first sampled at the next edge n
    @(negedge clk);          // after n
    @(negedge clk);          // after n+1
    chk("R12", "count before n+2", 32'(count), 32'h0);
    @(negedge clk);          // after n+2
    chk("R12", "count after n+2", 32'(count), 32'h1);
    mCnt = 16'h1; mIn = 1'b1;
    idle(2);
    chkState("R3");
    togglePin();             // falling edge, not counted with edgeSel=1
    chkState("R2");
    edgeSel = 1'b0;
    togglePin();             // rising, not counted
    togglePin();             // falling, counted
    chkState("R2");

    // R6 rollover, R7 write-one clear and write-zero ignore
    ovfIrqEn = 1'b1; inIrqEn = 1'b1;
    busWrite(2'd0, 16'hFFFF);
    togglePin(); togglePin(); // rise ignored, fall counted -> wrap
    chkState("R6");
    busWrite(2'd1, 16'h0000);
    chkState("R7");
    busWrite(2'd1, 16'h0002);
    chkState("R7");
    busRead(2'd1, "R7");

    // R8 fast clear
    togglePin(); togglePin(); // set input flag again
    busWrite(2'd0, 16'hFFFF);
    togglePin(); togglePin(); // overflow again
    fastClr = 1'b0;
    busRead(2'd0, "R8");
    chkState("R8");
    fastClr = 1'b1;
    busRead(2'd0, "R8");
    chkState("R8");
    fastClr = 1'b0;

    // R11 disabled: nothing changes
    accEn = 1'b0;
    togglePin(); togglePin();
    gateMode = 1'b1;
    tickPulse(); tickPulse();
    chkState("R11");

    // R4 / R5 gated mode, low window (edgeSel=1)
    accEn = 1'b1; gateMode = 1'b1; edgeSel = 1'b1;
    busWrite(2'd0, 16'h0010);
    tickPulse(); tickPulse(); tickPulse();
    chkState("R4");
    togglePin();             // rising = trailing edge of the low window
    chkState("R5");
    tickPulse();             // high level, not counted
    chkState("R4");
    busWrite(2'd1, 16'h0003);
    edgeSel = 1'b0;          // high window now active
    tickPulse(); tickPulse();
    chkState("R4");
    togglePin();             // falling = trailing edge
    chkState("R5");
    busWrite(2'd1, 16'h0001);
    togglePin();             // rising = leading edge, no flag
    chkState("R5");

    // R7 set and clear in the same cycle: set wins
    gateMode = 1'b0; edgeSel = 1'b0;
    togglePin();             // counted falling edge sets the flag
    @(negedge clk);
    pinRaw = 1'b1;           // sampled at edge n
    @(negedge clk);          // after n
    edgeSel = 1'b1;
    @(negedge clk);          // after n+1: strobe active during this cycle
    busAddr = 2'd1; busWdata = 16'h0003; busWr = 1'b1;
    @(negedge clk);          // after n+2
    busWr = 1'b0;
    mCnt = mCnt + 16'h1; mIn = 1'b1; mOvf = 1'b0;
    chkState("R7");

    // R9 load and increment in the same cycle: load wins
    @(negedge clk);
    pinRaw = 1'b0;
    @(negedge clk);
    edgeSel = 1'b0;
    @(negedge clk);
    busAddr = 2'd0; busWdata = 16'h1234; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
    mCnt = 16'h1234; mIn = 1'b1;
    chkState("R9");

    // random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      if ($urandom % 4 == 0) begin
        accEn    = ($urandom % 8) != 0;
        gateMode = $urandom % 2;
        edgeSel  = $urandom % 2;
        ovfIrqEn = $urandom % 2;
        inIrqEn  = $urandom % 2;
        fastClr  = ($urandom % 4) == 0;
      end
      op = $urandom % 7;
      case (op)
        0, 1: togglePin();
        2:    tickPulse();
        3:    busWrite(2'd0, ($urandom % 3 == 0) ? (16'hFFFE + 16'($urandom % 2))
                                                 : 16'($urandom));
        4:    busWrite(2'd1, 16'($urandom % 4));
        5:    busRead(2'd0, "R9");
        default: busRead(2'($urandom % 4), "R7");
      endcase
      chkState(gateMode ? "R4" : "R2");
    end

    done = 1'b1;
    finishRun();
  end

endmodule